// File: doc/BRIEF.md
# Dispatch Group Hazard Checker

This block follows how a superscalar front end packs instructions into a dispatch group, one candidate at a time. For each candidate it receives a class code and two count-register flags. It answers combinationally with a 2-bit hazard code. The code says the candidate may join the current group, that it must wait for a new group, or that a no-op must go in first. Opcode decoding and address comparison happen outside the block. The result of the store-to-load address comparison arrives as a single input bit.

Strobes advance the internal group state on the clock edge. An emit strobe commits the candidate. A no-op strobe spends one slot. A block-start strobe opens an empty group. The scheduler looks at the hazard code, then emits the candidate, inserts a no-op, or retries after the group rolls over.

Top module: `dgroup_hazard`

## Requirements
- R1: `hazard` is 2'b00 when the candidate may join the group, 2'b01 when it needs a new group, and 2'b10 when a no-op must be inserted first. 2'b11 never appears.
- R2: Class codes are 1 fixed-point, 2 load, 3 store, 4 floating-point, 5 condition-register, 6 vector ALU, 7 vector permute and 8 branch. Each group allows at most two fixed-point ops, two floating-point ops, two load/store ops (loads and stores share one count), and one each of condition-register, vector ALU and vector permute ops. A candidate whose own unit is full gets 2'b01. The candidate is checked only against the cap of its own class.
- R3: A group has five slots, and only a branch may fill the fifth. A non-branch candidate that arrives with four slots used gets 2'b01.
- R4: If an instruction that sets the count register has been emitted in the current group, a branch candidate with `ctr_branch` set gets 2'b10.
- R5: A load candidate with `addr_overlap` set gets 2'b10 when a store has been emitted in the current group. Without such a store, `addr_overlap` has no effect.
- R6: When a unit-cap or slot hazard and a no-op hazard apply together, the answer is 2'b01.
- R7: Codes 0 and 9 to 15 are pseudo instructions. They always get 2'b00, and emitting one changes no state.
- R8: Emitting a branch closes the group. The next candidate sees an empty group.
- R9: A no-op strobe uses one slot. When the fifth slot is used, every count and flag clears.
- R10: `block_start` empties the group and takes priority over emit and no-op in the same cycle.
- R11: A no-op strobe in the same cycle as the emit of a non-pseudo instruction is refused: no slot is spent for it, and `noop_err` is high in that cycle.
- R12: After reset the group is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_class | input | 4 | Class code of the candidate |
| ctr_write | input | 1 | Candidate sets the count register |
| ctr_branch | input | 1 | Candidate branches through the count register |
| addr_overlap | input | 1 | Candidate load overlaps the last store of the group |
| emit | input | 1 | Commit the candidate into the group |
| noop | input | 1 | Spend one slot on a no-op |
| block_start | input | 1 | Open a fresh group at a basic-block boundary |
| hazard | output | 2 | Hazard code for the candidate |
| noop_err | output | 1 | No-op refused because it coincided with an emit |

## Verification
The bench builds the block with its default parameters: five slots and a cap of two for each of the fixed-point, floating-point and load/store units. With these values, a third op of one class reaches a unit cap within three emits. Four mixed ops reach the branch-only last slot, and all the priority and rollover corners come up within a few cycles of each other. Directed sequences cover each rule. A long stretch of random candidates and strobes then runs against a behavioural model of the group.

// File: rtl/dgroup_hazard.sv
module dgroup_hazard #(
  parameter int SLOTS   = 5,
  parameter int FXU_CAP = 2,
  parameter int FPU_CAP = 2,
  parameter int LSU_CAP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cand_class,
  input  logic       ctr_write,
  input  logic       ctr_branch,
  input  logic       addr_overlap,
  input  logic       emit,
  input  logic       noop,
  input  logic       block_start,
  output logic [1:0] hazard,
  output logic       noop_err
);
  localparam int SW  = $clog2(SLOTS);
  localparam int FXW = $clog2(FXU_CAP + 1);
  localparam int FPW = $clog2(FPU_CAP + 1);
  localparam int LSW = $clog2(LSU_CAP + 1);
  localparam logic [3:0] C_FXU = 4'd1, C_LD = 4'd2, C_ST = 4'd3, C_FPU = 4'd4,
                         C_CR = 4'd5, C_VALU = 4'd6, C_VPERM = 4'd7, C_BR = 4'd8;

  logic [SW-1:0]  slots;
  logic [FXW-1:0] fxu_cnt;
  logic [FPW-1:0] fpu_cnt;
  logic [LSW-1:0] lsu_cnt;
  logic cr_used, valu_used, vperm_used, ctr_set, store_seen;

  wire is_pseudo = (cand_class == 4'd0) || (cand_class > C_BR);
  wire is_br     = cand_class == C_BR;
  wire is_ld     = cand_class == C_LD;
  wire is_st     = cand_class == C_ST;
  wire last_slot = slots == SW'(SLOTS - 1);

  logic cap_hit;
  always_comb begin
    case (cand_class)
      C_FXU:       cap_hit = fxu_cnt >= FXW'(FXU_CAP);
      C_LD, C_ST:  cap_hit = lsu_cnt >= LSW'(LSU_CAP);
      C_FPU:       cap_hit = fpu_cnt >= FPW'(FPU_CAP);
      C_CR:        cap_hit = cr_used;
      C_VALU:      cap_hit = valu_used;
      C_VPERM:     cap_hit = vperm_used;
      default:     cap_hit = 1'b0;
    endcase
  end

  wire group_hit = cap_hit || (last_slot && !is_br);
  wire noop_hit  = (is_br && ctr_branch && ctr_set) || (is_ld && addr_overlap && store_seen);

  assign hazard = is_pseudo ? 2'b00 : group_hit ? 2'b01 : noop_hit ? 2'b10 : 2'b00;

  wire real_emit = emit && !is_pseudo;
  wire take_noop = noop && !real_emit;
  assign noop_err = noop && real_emit;

  wire wipe = block_start || (real_emit && is_br) || ((real_emit || take_noop) && last_slot);

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      slots      <= '0;
      fxu_cnt    <= '0;
      fpu_cnt    <= '0;
      lsu_cnt    <= '0;
      cr_used    <= 1'b0;
      valu_used  <= 1'b0;
      vperm_used <= 1'b0;
      ctr_set    <= 1'b0;
      store_seen <= 1'b0;
    end else if (real_emit) begin
      slots <= slots + 1'b1;
      if (ctr_write) ctr_set <= 1'b1;
      if (is_st) store_seen <= 1'b1;
      case (cand_class)
        C_FXU:      fxu_cnt <= fxu_cnt + 1'b1;
        C_LD, C_ST: lsu_cnt <= lsu_cnt + 1'b1;
        C_FPU:      fpu_cnt <= fpu_cnt + 1'b1;
        C_CR:       cr_used <= 1'b1;
        C_VALU:     valu_used <= 1'b1;
        C_VPERM:    vperm_used <= 1'b1;
        default: ;
      endcase
    end else if (take_noop) begin
      slots <= slots + 1'b1;
    end
  end
endmodule

// File: rtl/dgroup_hazard_chk.sv
module dgroup_hazard_chk #(
  parameter int SLOTS = 5,
  parameter int SW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cand_class,
  input logic          emit,
  input logic          noop,
  input logic          block_start,
  input logic [1:0]    hazard,
  input logic          noop_err,
  input logic [SW-1:0] slots
);
  wire pseudo = (cand_class == 4'd0) || (cand_class > 4'd8);

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    hazard != 2'b11);                                                    // R1
  AST_SLOTS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slots < SW'(SLOTS));                                                 // R9
  AST_PSEUDO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    pseudo |-> hazard == 2'b00);                                         // R7
  AST_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slots == SW'(SLOTS - 1) && !pseudo && cand_class != 4'd8) |-> hazard == 2'b01); // R3
  AST_BLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    block_start |=> slots == '0);                                        // R10
  AST_BRANCH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && cand_class == 4'd8) |=> slots == '0);                       // R8
  AST_PSEUDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && pseudo && !noop && !block_start) |=> $stable(slots));       // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    noop_err |-> (noop && emit && !pseudo));                             // R11
endmodule

bind dgroup_hazard dgroup_hazard_chk #(.SLOTS(SLOTS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_class(cand_class), .emit(emit), .noop(noop),
  .block_start(block_start), .hazard(hazard), .noop_err(noop_err), .slots(slots)
);

// File: tb/tb_dgroup_hazard.sv
module tb_dgroup_hazard;
  localparam int SLOTS = 5, FXC = 2, FPC = 2, LSC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cand_class = '0;
  logic ctr_write = 0, ctr_branch = 0, addr_overlap = 0;
  logic emit = 0, noop = 0, block_start = 0;
  logic [1:0] hazard;
  logic noop_err;

  always #2 clk = ~clk;

  dgroup_hazard #(.SLOTS(SLOTS), .FXU_CAP(FXC), .FPU_CAP(FPC), .LSU_CAP(LSC)) dut (
    .clk(clk), .rst_n(rst_n), .cand_class(cand_class), .ctr_write(ctr_write),
    .ctr_branch(ctr_branch), .addr_overlap(addr_overlap), .emit(emit), .noop(noop),
    .block_start(block_start), .hazard(hazard), .noop_err(noop_err));

  int compared = 0, mismatched = 0;
  int m_slots, m_fx, m_fp, m_ls;
  bit m_cr, m_va, m_vp, m_ctr, m_st;

  function automatic bit pseudo_c(int c);
    return c == 0 || c > 8;
  endfunction

  function automatic void m_clear();
    m_slots = 0; m_fx = 0; m_fp = 0; m_ls = 0;
    m_cr = 0; m_va = 0; m_vp = 0; m_ctr = 0; m_st = 0;
  endfunction

  function automatic int m_hz(int c, bit cb, bit ov, output string tag);
    bit cap, slot, nh;
    if (pseudo_c(c)) begin tag = "R7"; return 0; end
    cap = (c == 1 && m_fx >= FXC) || ((c == 2 || c == 3) && m_ls >= LSC) ||
          (c == 4 && m_fp >= FPC) || (c == 5 && m_cr) || (c == 6 && m_va) || (c == 7 && m_vp);
    slot = (m_slots == SLOTS - 1) && c != 8;
    nh = (c == 8 && cb && m_ctr) || (c == 2 && ov && m_st);
    if (cap || slot) begin tag = nh ? "R6" : (cap ? "R2" : "R3"); return 1; end
    if (nh) begin tag = (c == 8) ? "R4" : "R5"; return 2; end
    tag = "R1";
    return 0;
  endfunction

  function automatic void m_update(int c, bit cw, bit em, bit np, bit bs);
    bit re = em && !pseudo_c(c);
    if (bs) begin m_clear(); return; end
    if (re) begin
      if (c == 8) begin m_clear(); return; end
      if (cw) m_ctr = 1;
      if (c == 3) m_st = 1;
      case (c)
        1: m_fx++;
        2, 3: m_ls++;
        4: m_fp++;
        5: m_cr = 1;
        6: m_va = 1;
        7: m_vp = 1;
        default: ;
      endcase
      m_slots++;
    end else if (np) m_slots++;
    if (m_slots >= SLOTS) m_clear();
  endfunction

  task automatic step(int c, bit cw, bit cb, bit ov, bit em, bit np, bit bs, string force_tag = "");
    string tag;
    int exp_h;
    bit exp_e;
    @(negedge clk);
    cand_class = 4'(c); ctr_write = cw; ctr_branch = cb; addr_overlap = ov;
    emit = em; noop = np; block_start = bs;
    #1;
    exp_h = m_hz(c, cb, ov, tag);
    if (force_tag != "") tag = force_tag;
    exp_e = np && em && !pseudo_c(c);
    compared++;
    if (hazard !== 2'(exp_h)) begin
      mismatched++;
      $display("FAIL %s hazard actual %0d expected %0d", tag, hazard, exp_h);
    end
    compared++;
    if (noop_err !== exp_e) begin
      mismatched++;
      $display("FAIL R11 noop_err actual %0b expected %0b", noop_err, exp_e);
    end
    @(posedge clk);
    m_update(c, cw, em, np, bs);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(4, 0, 0, 0, 0, 0, 0, "R12");
    // R2: third fixed-point op
    step(1, 0, 0, 0, 1, 0, 0); step(1, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(4, 0, 0, 0, 0, 0, 0, "R2");
    // R9: no-ops roll group over
    step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    // R3 / R8
    step(1, 0, 0, 0, 1, 0, 0); step(1, 0, 0, 0, 1, 0, 0);
    step(4, 0, 0, 0, 1, 0, 0); step(4, 0, 0, 0, 1, 0, 0);
    step(5, 0, 0, 0, 0, 0, 0, "R3");
    step(8, 0, 0, 0, 1, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0, 0, "R8");
    // R4 / R10
    step(1, 1, 0, 0, 1, 0, 0);
    step(8, 0, 1, 0, 0, 1, 0, "R4");
    step(8, 0, 1, 0, 0, 0, 0, "R4");
    step(8, 0, 1, 0, 1, 0, 1, "R10");
    step(8, 0, 1, 0, 0, 0, 0, "R10");
    // R5
    step(2, 0, 0, 1, 0, 0, 0, "R5");
    step(3, 0, 0, 0, 1, 0, 0);
    step(2, 0, 0, 1, 0, 0, 0, "R5");
    step(2, 0, 0, 0, 0, 0, 0, "R5");
    // R6
    step(3, 0, 0, 0, 1, 0, 0);
    step(2, 0, 0, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1);
    // R7: pseudo emits leave slot count alone
    step(1, 0, 0, 0, 1, 0, 0); step(1, 0, 0, 0, 1, 0, 0);
    step(4, 0, 0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 1, 0, 0, "R7"); step(12, 0, 0, 0, 1, 0, 0, "R7");
    step(4, 0, 0, 0, 0, 0, 0, "R7");
    step(8, 0, 1, 0, 0, 0, 0, "R7");
    step(6, 0, 0, 0, 1, 0, 0);
    step(5, 0, 0, 0, 0, 0, 0, "R7");
    // R11
    step(0, 0, 0, 0, 0, 0, 1);
    step(5, 0, 0, 0, 1, 1, 0, "R11");
    step(5, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4000; i++) begin
      int c, r, e;
      bit cw, cb, ov, em, np, bs;
      string t;
      c = $urandom_range(0, 9);
      if (c == 9) c = $urandom_range(9, 15);
      cw = $urandom_range(0, 3) == 0;
      cb = $urandom_range(0, 1);
      ov = $urandom_range(0, 1);
      r = $urandom_range(0, 99);
      e = m_hz(c, cb, ov, t);
      bs = r < 3;
      if (e == 0) begin em = r < 75; np = (r >= 85) || (r < 8); end
      else begin em = 0; np = r < 60; end
      step(c, cw, cb, ov, em, np, bs);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule